// File: doc/BRIEF.md
# Registered Dual-Product Adder with Feedback Operand

This block multiplies two pairs of 18-bit operands and merges the two products into one 36-bit result. An elaboration parameter fixes the merge as a sum or as a difference (first product minus second). Each operand side has its own signedness control. Two run-time controls select rounding and saturation of the result. An overflow flag reports every cycle in which saturation clamped the value.

A second parameter turns on a feedback configuration. The upper 18 bits of the registered result become the a-operand of the first multiplier, the low 18 bits are dropped, and the external input for that operand is ignored. A run-time control forces the fed-back operand to zero, which seeds or restarts a recursion such as a first-order filter. The data path has two register stages: operands and controls are captured on the way in, and the result is captured on the way out. A clock enable gates both stages, and an asynchronous clear empties them.

Top module: `pair_product_combiner`

## Requirements
- R1: The result is p0 + p1 when SUBTRACT = 0 and p0 - p1 when SUBTRACT = 1, where p0 = op_a0 x op_b0 and p1 = op_a1 x op_b1. With saturation off, the result is the low 36 bits of the exact value in two's complement.
- R2: sign_a = 1 reads op_a0 and op_a1 as two's complement, and sign_a = 0 reads them as unsigned. sign_b controls op_b0 and op_b1 in the same way.
- R3: Operands and controls sampled at an enabled clock edge determine the result after the next enabled edge, so the latency is two enabled edges.
- R4: While en is 0, the input and output registers hold their values, and result and overflow do not change.
- R5: When aclr is 1, result and overflow go to zero at once without a clock edge, and the captured operands and controls are cleared.
- R6: With round_en = 1, 2^17 is added to the combined value and the low 18 bits of the result are then forced to zero.
- R7: With sat_en = 1, the allowed range is signed 36-bit (-2^35 .. 2^35-1) when either sign control is 1, and 0 .. 2^36-1 when both are 0. A value outside the range is clamped to the nearer limit and overflow is 1 for that result. With sat_en = 0, overflow is 0.
- R8: With LOOPBACK = 1, the first multiplier's a-operand is bits 35:18 of the current registered result, read with sign_a, and op_a0 has no effect.
- R9: In feedback configuration, zero_fb = 1 (captured with the other inputs) makes the fed-back operand zero for that result, and zero_fb = 0 passes the feedback through.
- R10: When rounding and saturation are both on, the range check applies to the rounded value, so a value just inside the limit can be pushed over by rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| aclr | input | 1 | Asynchronous clear, active high |
| en | input | 1 | Clock enable for both register stages |
| op_a0 | input | 18 | a-operand of the first multiplier (ignored in feedback configuration) |
| op_b0 | input | 18 | b-operand of the first multiplier |
| op_a1 | input | 18 | a-operand of the second multiplier |
| op_b1 | input | 18 | b-operand of the second multiplier |
| sign_a | input | 1 | 1 = a-side operands are signed |
| sign_b | input | 1 | 1 = b-side operands are signed |
| round_en | input | 1 | Enable rounding at bit 17 |
| sat_en | input | 1 | Enable saturation |
| zero_fb | input | 1 | 1 = zero the fed-back operand |
| result | output | 36 | Registered combined result |
| overflow | output | 1 | Registered saturation flag |

## Verification
Rounding and saturation can act on the same result. The bench provokes this with products whose sum lies 2^17 below the signed upper limit. Without rounding the value must pass unclamped with overflow low. With rounding it must reach the limit, be clamped to 2^35-1 and raise overflow. The feedback recursion and the zero control also meet in one cycle: the bench sets zero_fb while the loop is running. It then expects the reseeded value two edges later and the recursion to resume from that value, with op_a0 toggled throughout to show that it has no effect.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  // Per-result control bits captured together with the operands.
  typedef struct packed {
    logic sgn_a;
    logic sgn_b;
    logic rnd;
    logic sat;
    logic zero_fb;
  } ppc_ctrl_t;

  localparam int unsigned PPC_LANES = 4;

endpackage

// File: rtl/ppc_in_stage.sv
module ppc_in_stage
  import ppc_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned LANES = PPC_LANES
) (
  input  logic                       clk,
  input  logic                       aclr,
  input  logic                       en,
  input  logic [LANES-1:0][DW-1:0]   ops_d,
  input  ppc_ctrl_t                  ctrl_d,
  output logic [LANES-1:0][DW-1:0]   ops_q,
  output ppc_ctrl_t                  ctrl_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or posedge aclr) begin
      if (aclr)    ops_q[g] <= '0;
      else if (en) ops_q[g] <= ops_d[g];
    end
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)    ctrl_q <= '0;
    else if (en) ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/ppc_arith.sv
module ppc_arith
  import ppc_pkg::*;
#(
  parameter int unsigned DW       = 18,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic [DW-1:0]   a0,
  input  logic [DW-1:0]   b0,
  input  logic [DW-1:0]   a1,
  input  logic [DW-1:0]   b1,
  input  ppc_ctrl_t       ctrl,
  output logic [2*DW-1:0] res_o,
  output logic            range_exceeded_o,
  output logic            sat_event_o
);

  localparam int unsigned EW = DW + 1;     // operand with sign/zero extension
  localparam int unsigned PW = 2 * EW;     // exact product
  localparam int unsigned SW = PW + 2;     // sum plus rounding headroom
  localparam int unsigned RW = 2 * DW;     // visible result

  function automatic logic signed [EW-1:0] extend_op(input logic [DW-1:0] v,
                                                     input logic is_signed);
    return is_signed ? $signed({v[DW-1], v}) : $signed({1'b0, v});
  endfunction

  function automatic logic signed [PW-1:0] mul_op(input logic signed [EW-1:0] x,
                                                  input logic signed [EW-1:0] y);
    logic signed [PW-1:0] xw;
    logic signed [PW-1:0] yw;
    xw = PW'(x);
    yw = PW'(y);
    return xw * yw;
  endfunction

  function automatic logic signed [SW-1:0] merge(input logic signed [PW-1:0] p0,
                                                 input logic signed [PW-1:0] p1);
    logic signed [SW-1:0] w0;
    logic signed [SW-1:0] w1;
    w0 = SW'(p0);
    w1 = SW'(p1);
    return SUBTRACT ? (w0 - w1) : (w0 + w1);
  endfunction

  function automatic logic signed [SW-1:0] round_half(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] t;
    t = s + (SW'(1) << (DW - 1));
    return $signed({t[SW-1:DW], {DW{1'b0}}});
  endfunction

  function automatic logic out_of_range(input logic signed [SW-1:0] s,
                                        input logic signed_range);
    logic [SW-RW:0] hi_s;
    logic [SW-RW-1:0] hi_u;
    hi_s = s[SW-1:RW-1];
    hi_u = s[SW-1:RW];
    if (signed_range) return !((&hi_s) || (~|hi_s));
    else              return |hi_u;
  endfunction

  function automatic logic [RW-1:0] clamp_value(input logic negative,
                                                input logic signed_range);
    if (signed_range) return negative ? {1'b1, {(RW-1){1'b0}}} : {1'b0, {(RW-1){1'b1}}};
    else              return negative ? '0 : '1;
  endfunction

  logic signed [EW-1:0] xa0, xb0, xa1, xb1;
  logic signed [PW-1:0] prod0, prod1;
  logic signed [SW-1:0] combined, shaped;
  logic                 signed_range;

  always_comb begin
    xa0          = extend_op(a0, ctrl.sgn_a);
    xb0          = extend_op(b0, ctrl.sgn_b);
    xa1          = extend_op(a1, ctrl.sgn_a);
    xb1          = extend_op(b1, ctrl.sgn_b);
    prod0        = mul_op(xa0, xb0);
    prod1        = mul_op(xa1, xb1);
    combined     = merge(prod0, prod1);
    shaped       = ctrl.rnd ? round_half(combined) : combined;
    signed_range = ctrl.sgn_a | ctrl.sgn_b;
    range_exceeded_o = out_of_range(shaped, signed_range);
    sat_event_o  = ctrl.sat & range_exceeded_o;
    res_o        = sat_event_o ? clamp_value(shaped[SW-1], signed_range)
                               : shaped[RW-1:0];
  end

endmodule

// File: rtl/ppc_out_stage.sv
module ppc_out_stage #(
  parameter int unsigned DW = 18
) (
  input  logic            clk,
  input  logic            aclr,
  input  logic            en,
  input  logic [2*DW-1:0] res_d,
  input  logic            ovf_d,
  output logic [2*DW-1:0] res_q,
  output logic            ovf_q,
  output logic [DW-1:0]   fb_o
);

  localparam int unsigned RW = 2 * DW;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (en) begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  // Upper half of the registered result; the low half is not fed back.
  assign fb_o = res_q[RW-1:DW];

endmodule

// File: rtl/pair_product_combiner.sv
module pair_product_combiner
  import ppc_pkg::*;
#(
  parameter int unsigned DW       = 18,
  parameter bit          SUBTRACT = 1'b0,
  parameter bit          LOOPBACK = 1'b0
) (
  input  logic            clk,
  input  logic            aclr,
  input  logic            en,
  input  logic [DW-1:0]   op_a0,
  input  logic [DW-1:0]   op_b0,
  input  logic [DW-1:0]   op_a1,
  input  logic [DW-1:0]   op_b1,
  input  logic            sign_a,
  input  logic            sign_b,
  input  logic            round_en,
  input  logic            sat_en,
  input  logic            zero_fb,
  output logic [2*DW-1:0] result,
  output logic            overflow
);

  localparam int unsigned RW = 2 * DW;

  logic [PPC_LANES-1:0][DW-1:0] ops_d, ops_q;
  ppc_ctrl_t                    ctrl_d, ctrl_q;
  logic [DW-1:0]                fb_word;
  logic [DW-1:0]                a0_used;
  logic [RW-1:0]                res_next;
  logic                         range_exceeded;
  logic                         sat_event;
  logic                         sat_armed;
  logic                         round_armed;

  assign ops_d  = {op_b1, op_a1, op_b0, op_a0};
  assign ctrl_d = '{sgn_a: sign_a, sgn_b: sign_b, rnd: round_en,
                    sat: sat_en, zero_fb: zero_fb};

  ppc_in_stage #(.DW(DW), .LANES(PPC_LANES)) u_in (
    .clk    (clk),
    .aclr   (aclr),
    .en     (en),
    .ops_d  (ops_d),
    .ctrl_d (ctrl_d),
    .ops_q  (ops_q),
    .ctrl_q (ctrl_q)
  );

  // First multiplier a-operand: captured input, or the fed-back upper half.
  always_comb begin
    if (LOOPBACK) a0_used = ctrl_q.zero_fb ? '0 : fb_word;
    else          a0_used = ops_q[0];
  end

  ppc_arith #(.DW(DW), .SUBTRACT(SUBTRACT)) u_arith (
    .a0               (a0_used),
    .b0               (ops_q[1]),
    .a1               (ops_q[2]),
    .b1               (ops_q[3]),
    .ctrl             (ctrl_q),
    .res_o            (res_next),
    .range_exceeded_o (range_exceeded),
    .sat_event_o      (sat_event)
  );

  ppc_out_stage #(.DW(DW)) u_out (
    .clk   (clk),
    .aclr  (aclr),
    .en    (en),
    .res_d (res_next),
    .ovf_d (sat_event),
    .res_q (result),
    .ovf_q (overflow),
    .fb_o  (fb_word)
  );

  // Named copies of captured controls for the checker.
  assign sat_armed   = ctrl_q.sat;
  assign round_armed = ctrl_q.rnd;

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int unsigned DW = 18
) (
  input logic            clk,
  input logic            aclr,
  input logic            en,
  input logic [2*DW-1:0] result,
  input logic            overflow,
  input logic            sat_armed,
  input logic            round_armed
);

  localparam int unsigned RW = 2 * DW;
  localparam logic [RW-1:0] SMAX = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] SMIN = {1'b1, {(RW-1){1'b0}}};

  AST_CLEAR_EMPTIES: assert property (@(posedge clk)
    aclr |-> (result == '0 && !overflow));  // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (aclr)
    !en |=> ($stable(result) && $stable(overflow)));  // R4

  AST_ROUND_LOW_CLEAR: assert property (@(posedge clk) disable iff (aclr)
    (en && round_armed && !sat_armed) |=> (result[DW-1:0] == '0));  // R6

  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (aclr)
    overflow |-> (result == SMAX || result == SMIN || result == '0 || result == '1));  // R7

  AST_NO_SAT_NO_OVF: assert property (@(posedge clk) disable iff (aclr)
    (en && !sat_armed) |=> !overflow);  // R7

endmodule

bind pair_product_combiner ppc_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .aclr        (aclr),
  .en          (en),
  .result      (result),
  .overflow    (overflow),
  .sat_armed   (sat_armed),
  .round_armed (round_armed)
);

// File: tb/sim_pair_product_combiner.sv
`timescale 1ns/1ps
module sim_pair_product_combiner;

  localparam int unsigned DW = 18;
  localparam int unsigned RW = 2 * DW;

  logic clk = 1'b0;
  logic aclr = 1'b1;
  logic en = 1'b0;
  logic [DW-1:0] op_a0 = '0, op_b0 = '0, op_a1 = '0, op_b1 = '0;
  logic sign_a = 1'b0, sign_b = 1'b0, round_en = 1'b0, sat_en = 1'b0, zero_fb = 1'b0;
  logic [RW-1:0] res0, res1, res2;
  logic ov0, ov1, ov2;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Sum, no feedback
  pair_product_combiner #(.DW(DW), .SUBTRACT(1'b0), .LOOPBACK(1'b0)) u0 (
    .clk(clk), .aclr(aclr), .en(en), .op_a0(op_a0), .op_b0(op_b0), .op_a1(op_a1),
    .op_b1(op_b1), .sign_a(sign_a), .sign_b(sign_b), .round_en(round_en),
    .sat_en(sat_en), .zero_fb(zero_fb), .result(res0), .overflow(ov0));
  // Sum, feedback
  pair_product_combiner #(.DW(DW), .SUBTRACT(1'b0), .LOOPBACK(1'b1)) u1 (
    .clk(clk), .aclr(aclr), .en(en), .op_a0(op_a0), .op_b0(op_b0), .op_a1(op_a1),
    .op_b1(op_b1), .sign_a(sign_a), .sign_b(sign_b), .round_en(round_en),
    .sat_en(sat_en), .zero_fb(zero_fb), .result(res1), .overflow(ov1));
  // Difference, no feedback
  pair_product_combiner #(.DW(DW), .SUBTRACT(1'b1), .LOOPBACK(1'b0)) u2 (
    .clk(clk), .aclr(aclr), .en(en), .op_a0(op_a0), .op_b0(op_b0), .op_a1(op_a1),
    .op_b1(op_b1), .sign_a(sign_a), .sign_b(sign_b), .round_en(round_en),
    .sat_en(sat_en), .zero_fb(zero_fb), .result(res2), .overflow(ov2));

  // Reference from the requirements, in 64-bit integer arithmetic.
  function automatic void model(input logic [DW-1:0] a0, b0, a1, b1,
                                input bit sa, sb, rnd, sat, sub,
                                output logic [RW-1:0] r, output bit ov);
    longint x0, y0, x1, y1, s, hi, lo;
    x0 = sa ? longint'($signed(a0)) : longint'(a0);
    x1 = sa ? longint'($signed(a1)) : longint'(a1);
    y0 = sb ? longint'($signed(b0)) : longint'(b0);
    y1 = sb ? longint'($signed(b1)) : longint'(b1);
    s  = sub ? (x0 * y0 - x1 * y1) : (x0 * y0 + x1 * y1);
    if (rnd) s = (s + 64'sd131072) & ~64'sd262143;
    if (sa || sb) begin hi = (64'sd1 <<< 35) - 1; lo = -(64'sd1 <<< 35); end
    else          begin hi = (64'sd1 <<< 36) - 1; lo = 0; end
    ov = 1'b0;
    if (sat && s > hi)      begin s = hi; ov = 1'b1; end
    else if (sat && s < lo) begin s = lo; ov = 1'b1; end
    r = s[RW-1:0];
  endfunction

  task automatic chk(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp,
                     input logic aov, input logic eov);
    n_chk++;
    if (act !== exp || aov !== eov) begin
      n_err++;
      $display("FAIL %s: result=%h overflow=%b expected result=%h overflow=%b",
               req, act, eov === aov ? aov : aov, exp, eov);
    end
  endtask

  task automatic drive(input logic [DW-1:0] a0, b0, a1, b1, input bit sa, sb, rnd, sat, zf);
    op_a0 = a0; op_b0 = b0; op_a1 = a1; op_b1 = b1;
    sign_a = sa; sign_b = sb; round_en = rnd; sat_en = sat; zero_fb = zf;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // Expected for the non-feedback instances given current inputs
  task automatic expect_plain(input string req, input bit sub_dut);
    logic [RW-1:0] r; bit ov;
    model(op_a0, op_b0, op_a1, op_b1, sign_a, sign_b, round_en, sat_en, sub_dut, r, ov);
    if (sub_dut) chk(req, res2, r, ov2, ov);
    else         chk(req, res0, r, ov0, ov);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R5 reset u0", res0, '0, ov0, 1'b0);
    chk("R5 reset u1", res1, '0, ov1, 1'b0);
    aclr = 1'b0; en = 1'b1;
  endtask

  task automatic t_basic();
    drive(18'd1234, 18'd5678, 18'd91011, 18'd77, 1, 1, 0, 0, 0); settle();
    expect_plain("R1 sum signed", 0);
    expect_plain("R1 difference signed", 1);
    drive(18'h3FFF0, 18'd300, 18'd25, 18'h3FFFF, 1, 1, 0, 0, 0); settle();
    expect_plain("R1 sum negatives", 0);
    expect_plain("R1 difference negatives", 1);
  endtask

  task automatic t_signs();
    drive(18'h3FFFE, 18'h3FFFF, 18'h3FFFE, 18'd3, 1, 0, 0, 0, 0); settle();
    expect_plain("R2 a signed b unsigned", 0);
    drive(18'h3FFFE, 18'h3FFFF, 18'h3FFFE, 18'd3, 0, 1, 0, 0, 0); settle();
    expect_plain("R2 a unsigned b signed", 0);
    drive(18'h3FFFE, 18'h3FFFF, 18'h3FFFE, 18'd3, 0, 0, 0, 0, 0); settle();
    expect_plain("R2 both unsigned", 0);
    drive(18'd1, 18'd1, 18'd2, 18'd2, 0, 0, 0, 0, 0); settle();
    chk("R1 unsigned difference wraps", res2, 36'hF_FFFF_FFFD, ov2, 1'b0);
  endtask

  task automatic t_latency();
    logic [RW-1:0] rp; bit op;
    drive(18'd10, 18'd20, 18'd30, 18'd40, 1, 1, 0, 0, 0); settle();
    model(18'd10, 18'd20, 18'd30, 18'd40, 1, 1, 0, 0, 0, rp, op);
    chk("R3 first value", res0, rp, ov0, op);
    drive(18'd111, 18'd222, 18'd3, 18'd4, 1, 1, 0, 0, 0);
    @(negedge clk);
    chk("R3 unchanged after one edge", res0, rp, ov0, op);
    @(negedge clk);
    expect_plain("R3 new value after two edges", 0);
  endtask

  task automatic t_enable();
    logic [RW-1:0] rp; bit op;
    drive(18'd500, 18'd600, 18'd7, 18'd8, 1, 1, 0, 0, 0); settle();
    model(18'd500, 18'd600, 18'd7, 18'd8, 1, 1, 0, 0, 0, rp, op);
    chk("R4 before hold", res0, rp, ov0, op);
    en = 1'b0;
    drive(18'h20000, 18'h20000, 18'h20000, 18'h20000, 1, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    chk("R4 held while disabled", res0, rp, ov0, op);
    en = 1'b1; settle();
    expect_plain("R4 resumes after enable", 0);
  endtask

  task automatic t_round();
    drive(18'd3, 18'd100000, 18'd0, 18'd0, 1, 1, 1, 0, 0); settle();
    expect_plain("R6 round positive", 0);
    chk("R6 round positive value", res0, 36'd262144, ov0, 1'b0);
    drive(18'h3FFFD, 18'd50000, 18'd1, 18'd7, 1, 1, 1, 0, 0); settle();
    expect_plain("R6 round negative", 0);
  endtask

  task automatic t_sat();
    drive(18'h20000, 18'h20000, 18'h20000, 18'h20000, 1, 1, 0, 1, 0); settle();
    chk("R7 signed positive clamp", res0, 36'h7_FFFF_FFFF, ov0, 1'b1);
    drive(18'h20000, 18'h20000, 18'h20000, 18'h20000, 1, 1, 0, 0, 0); settle();
    chk("R7 no clamp when off", res0, 36'h8_0000_0000, ov0, 1'b0);
    drive(18'h20000, 18'h3FFFF, 18'h20000, 18'h3FFFF, 1, 0, 0, 1, 0); settle();
    chk("R7 signed negative clamp", res0, 36'h8_0000_0000, ov0, 1'b1);
    drive(18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 18'h3FFFF, 0, 0, 0, 1, 0); settle();
    chk("R7 unsigned upper clamp", res0, 36'hF_FFFF_FFFF, ov0, 1'b1);
    drive(18'd1, 18'd1, 18'd2, 18'd2, 0, 0, 0, 1, 0); settle();
    chk("R7 unsigned lower clamp", res2, 36'h0, ov2, 1'b1);
    drive(18'd9, 18'd9, 18'd2, 18'd2, 0, 0, 0, 1, 0); settle();
    chk("R7 in range passes", res2, 36'd77, ov2, 1'b0);
  endtask

  task automatic t_round_sat();
    drive(18'h20000, 18'h20000, 18'h20000, 18'h20001, 1, 1, 0, 1, 0); settle();
    chk("R10 just inside without rounding", res0, 36'h7_FFFE_0000, ov0, 1'b0);
    drive(18'h20000, 18'h20000, 18'h20000, 18'h20001, 1, 1, 1, 1, 0); settle();
    chk("R10 rounding pushes into clamp", res0, 36'h7_FFFF_FFFF, ov0, 1'b1);
    expect_plain("R10 model agrees", 0);
  endtask

  task automatic t_clear();
    drive(18'd700, 18'd800, 18'd900, 18'd1000, 1, 1, 0, 0, 0); settle();
    expect_plain("R5 value before clear", 0);
    #2 aclr = 1'b1;
    #1 chk("R5 async clear without edge", res0, '0, ov0, 1'b0);
    #1 aclr = 1'b0;
    @(negedge clk);
    chk("R5 operands cleared too", res0, '0, ov0, 1'b0);
    @(negedge clk);
    expect_plain("R5 recovers", 0);
  endtask

  task automatic t_loop();
    logic [RW-1:0] m; bit mo;
    logic [DW-1:0] fb;
    @(negedge clk);
    #1 aclr = 1'b1;
    #1 aclr = 1'b0;
    drive(18'd5, 18'd65536, 18'd1000, 18'd131072, 0, 0, 0, 0, 0);
    fb = '0;
    settle();
    for (int k = 0; k < 5; k++) begin
      model(fb, 18'd65536, 18'd1000, 18'd131072, 0, 0, 0, 0, 0, m, mo);
      chk("R8 feedback recursion", res1, m, ov1, mo);
      fb = m[RW-1:DW];
      op_a0 = 18'(k * 4099 + 17);   // R8: must have no effect
      @(negedge clk);
    end
    // Zero the feedback while the loop runs (R9)
    zero_fb = 1'b1;
    @(negedge clk);
    op_a0 = 18'h2AAAA;
    @(negedge clk);
    model(18'd0, 18'd65536, 18'd1000, 18'd131072, 0, 0, 0, 0, 0, m, mo);
    chk("R9 zeroed feedback", res1, m, ov1, mo);
    @(negedge clk);
    chk("R9 stays zeroed", res1, m, ov1, mo);
    zero_fb = 1'b0;
    fb = m[RW-1:DW];
    @(negedge clk);
    chk("R9 one more zeroed result", res1, m, ov1, mo);
    @(negedge clk);
    model(fb, 18'd65536, 18'd1000, 18'd131072, 0, 0, 0, 0, 0, m, mo);
    chk("R9 recursion resumes", res1, m, ov1, mo);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_signs();
    t_latency();
    t_enable();
    t_round();
    t_sat();
    t_round_sat();
    t_clear();
    t_loop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule